// File: doc/BRIEF.md
# Sample-Rate Change Resynchronisation Controller

This block is the host-facing register front end that manages sample-clock reconfiguration in a codec. A host reaches three byte-wide registers over a simple strobed bus. The control register holds a change-permit flag. The rate register holds a four-bit data-format field and two clock fields: a divide select and a base select. A third register holds an alternate-rate flag. When that flag is set, the clock fields stop steering the sample frequency.

The clock fields can be reprogrammed only while the change-permit flag is set. A write that actually changes them starts a resynchronisation window of fixed length. During that window the block drops every host write, and every host read returns 0x80. The host polls the control register until 0x80 stops coming back, and may then clear the change-permit flag. The clock generator itself sits outside this block and consumes the field outputs.

Top module: `rate_resync_ctrl`

## Requirements
- R1: After a synchronous active-low reset, busy is 0, the change-permit flag (control bit 6) and the alternate-rate flag (alt register bit 0) are 0, all rate fields are 0, and a read of the control register returns 0x00.
- R2: Writing address 0 sets the change-permit flag from write-data bit 6. A read of address 0 while idle returns the flag in bit 6 and zeros in every other bit, including bit 7.
- R3: Address 1 maps format to bits 7:4, divide select to bits 3:1 and base select to bit 0. While the change-permit flag is set, a write to address 1 whose bits 3:0 differ from the stored clock fields updates all eight bits and raises busy on the next clock.
- R4: Once raised, busy stays high for exactly RESYNC_LEN clocks (64 by default) and then falls.
- R5: While busy is high, host writes to any address change no register.
- R6: A read strobed while busy is high returns 0x80 at any address. Reads after busy falls return the normal register contents.
- R7: A write to address 1 while the change-permit flag is clear updates only the format bits. The clock fields keep their values and busy stays low.
- R8: A write to address 1 with the change-permit flag set and bits 3:0 equal to the stored clock fields updates the format bits and does not raise busy.
- R9: Address 2 bit 0 is the alternate-rate flag and reads back in bit 0. The output clk_fields_live is 1 exactly when the flag is 0.
- R10: Read data is registered: host_rdata shows the result one clock after the read strobe and holds its value until the next strobe. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_wr | input | 1 | Write strobe, one clock per access |
| host_rd | input | 1 | Read strobe, one clock per access |
| smp_tick | input | 1 | Sample tick; paces the window when TICK_MODE is 1 |
| host_rdata | output | 8 | Registered read data |
| mce | output | 1 | Change-permit flag |
| alt_rate_en | output | 1 | Alternate-rate flag |
| fmt_bits | output | 4 | Data-format field |
| clk_div_sel | output | 3 | Clock divide select |
| clk_base_sel | output | 1 | Clock base select |
| clk_fields_live | output | 1 | Clock fields currently steer the rate |
| busy | output | 1 | Resynchronisation window active |

## Verification
Register and flag outputs, and busy, change on the first clock after the write strobe. host_rdata is due one clock after the read strobe. The bench drives strobes on the falling edge and samples on the next falling edge, so every check falls exactly one register stage after its stimulus. A behavioural model advances on the same rising edges and is compared with every output at each falling edge. The length of the busy window is counted in whole clocks from its first high sample to its first low sample.

// File: rtl/rrc_pkg.sv
// Package: shared address map and field positions for the resync controller.
// Assumes a two-bit host address and byte-wide registers.
package rrc_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int FMT_W    = 4;
    localparam int DIV_W    = 3;
    localparam int CLKF_W   = DIV_W + 1;
    localparam int MCE_BIT  = 6;
    localparam int ALT_BIT  = 0;
    localparam logic [DATA_W-1:0] BUSY_READ = 8'h80;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 2'd0,
        A_RATE  = 2'd1,
        A_ALT   = 2'd2,
        A_SPARE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [FMT_W-1:0] fmt;
        logic [DIV_W-1:0] div;
        logic             base;
    } rate_reg_t;
endpackage

// File: rtl/rrc_resync_timer.sv
// Module: counts out the resynchronisation window after a start pulse.
// Assumes start is only pulsed while the window is idle.
module rrc_resync_timer #(
    parameter int RESYNC_LEN = 64,
    parameter int TICK_MODE  = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic smp_tick,
    output logic busy
);
    localparam int CNT_W = $clog2(RESYNC_LEN + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(RESYNC_LEN);

    logic [CNT_W-1:0] remain_q;
    logic             step;

    // Select what paces the window: every clock or every sample tick.
    generate
        if (TICK_MODE == 0) begin : g_clk_pace
            assign step = 1'b1 | smp_tick;
        end else begin : g_tick_pace
            assign step = smp_tick;
        end
    endgenerate

    // Load on start, otherwise count down while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start && remain_q == '0) begin
            remain_q <= LOAD;
        end else if (remain_q != '0 && step) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy = (remain_q != '0);

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R3
    AST_WINDOW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        remain_q <= LOAD); // R4
endmodule

// File: rtl/rrc_regfile.sv
// Module: host-writable registers with gated clock-field updates.
// Assumes writes arrive as single-clock strobes; all writes are dropped while busy.
module rrc_regfile
    import rrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    output logic              mce_q,
    output logic              alt_q,
    output rate_reg_t         rate_q,
    output logic              start
);
    logic             wr_ok;
    logic [CLKF_W-1:0] new_clk;
    logic [CLKF_W-1:0] cur_clk;

    assign wr_ok   = wr_en && !busy;
    assign new_clk = wdata[CLKF_W-1:0];
    assign cur_clk = {rate_q.div, rate_q.base};

    // Flag a clock change that is permitted and actually alters the fields.
    always_comb begin
        start = wr_ok && (addr == A_RATE) && mce_q && (new_clk != cur_clk);
    end

    // Register updates; the clock fields move only under the change-permit flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mce_q  <= 1'b0;
            alt_q  <= 1'b0;
            rate_q <= '0;
        end else if (wr_ok) begin
            case (addr)
                A_CTRL: mce_q <= wdata[MCE_BIT];
                A_RATE: begin
                    rate_q.fmt <= wdata[DATA_W-1:CLKF_W];
                    if (mce_q) begin
                        rate_q.div  <= wdata[CLKF_W-1:1];
                        rate_q.base <= wdata[0];
                    end
                end
                A_ALT:  alt_q <= wdata[ALT_BIT];
                default: ;
            endcase
        end
    end

    AST_BUSY_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> ($stable(mce_q) && $stable(alt_q) && $stable(rate_q))); // R5
    AST_CLK_HELD_NO_MCE: assert property (@(posedge clk) disable iff (!rst_n)
        !mce_q |=> ($stable(rate_q.div) && $stable(rate_q.base))); // R7
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R5
endmodule

// File: rtl/rrc_read_port.sv
// Module: registered host read path with the busy override.
// Assumes register contents are stable for the clock in which the read strobe is high.
module rrc_read_port
    import rrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    input  logic              mce_q,
    input  logic              alt_q,
    input  rate_reg_t         rate_q,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] sel;

    // Pick the addressed register image.
    always_comb begin
        sel = '0;
        case (addr)
            A_CTRL:  sel[MCE_BIT] = mce_q;
            A_RATE:  sel = rate_q;
            A_ALT:   sel[ALT_BIT] = alt_q;
            default: sel = '0;
        endcase
    end

    // Capture on the strobe; the busy pattern overrides the register image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= busy ? BUSY_READ : sel;
        end
    end

    AST_BUSY_READ_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (rdata == BUSY_READ)); // R6
    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R10
endmodule

// File: rtl/rate_resync_ctrl.sv
// Module: top of the sample-rate change resync controller.
// Assumes a single host master and a clock generator that consumes the field outputs.
module rate_resync_ctrl #(
    parameter int RESYNC_LEN = 64,
    parameter int TICK_MODE  = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] host_addr,
    input  logic [7:0] host_wdata,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       smp_tick,
    output logic [7:0] host_rdata,
    output logic       mce,
    output logic       alt_rate_en,
    output logic [3:0] fmt_bits,
    output logic [2:0] clk_div_sel,
    output logic       clk_base_sel,
    output logic       clk_fields_live,
    output logic       busy
);
    import rrc_pkg::*;

    logic      mce_q;
    logic      alt_q;
    rate_reg_t rate_q;
    logic      start;
    logic      busy_w;

    rrc_regfile u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (host_wr),
        .addr   (host_addr),
        .wdata  (host_wdata),
        .busy   (busy_w),
        .mce_q  (mce_q),
        .alt_q  (alt_q),
        .rate_q (rate_q),
        .start  (start)
    );

    rrc_resync_timer #(
        .RESYNC_LEN (RESYNC_LEN),
        .TICK_MODE  (TICK_MODE)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .smp_tick (smp_tick),
        .busy     (busy_w)
    );

    rrc_read_port u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (host_rd),
        .addr   (host_addr),
        .busy   (busy_w),
        .mce_q  (mce_q),
        .alt_q  (alt_q),
        .rate_q (rate_q),
        .rdata  (host_rdata)
    );

    // Drive the field outputs from the register image.
    always_comb begin
        mce             = mce_q;
        alt_rate_en     = alt_q;
        fmt_bits        = rate_q.fmt;
        clk_div_sel     = rate_q.div;
        clk_base_sel    = rate_q.base;
        clk_fields_live = !alt_q;
        busy            = busy_w;
    end

    AST_LIVE_FOLLOWS_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fields_live != alt_rate_en); // R9
endmodule

// File: tb/sim_rate_resync_ctrl.sv
module sim_rate_resync_ctrl;
    localparam int WIN = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic       smp_tick = 1'b0;
    logic [7:0] host_rdata;
    logic       mce, alt_rate_en, clk_base_sel, clk_fields_live, busy;
    logic [3:0] fmt_bits;
    logic [2:0] clk_div_sel;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // reference model state
    int m_left = 0;
    int m_mce = 0, m_alt = 0, m_fmt = 0, m_clk = 0, m_rd = 0;

    always #2 clk = ~clk;

    rate_resync_ctrl #(.RESYNC_LEN(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_wr(host_wr), .host_rd(host_rd), .smp_tick(smp_tick),
        .host_rdata(host_rdata), .mce(mce), .alt_rate_en(alt_rate_en),
        .fmt_bits(fmt_bits), .clk_div_sel(clk_div_sel), .clk_base_sel(clk_base_sel),
        .clk_fields_live(clk_fields_live), .busy(busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_mce = 0; m_alt = 0; m_fmt = 0; m_clk = 0; m_rd = 0;
        end else begin
            int was_busy;
            was_busy = (m_left != 0);
            if (host_rd) begin
                if (was_busy) m_rd = 'h80;
                else case (host_addr)
                    0: m_rd = m_mce * 'h40;
                    1: m_rd = m_fmt * 16 + m_clk;
                    2: m_rd = m_alt;
                    default: m_rd = 0;
                endcase
            end
            if (was_busy) m_left = m_left - 1;
            else if (host_wr) begin
                case (host_addr)
                    0: m_mce = (host_wdata >> 6) & 1;
                    1: begin
                        m_fmt = host_wdata >> 4;
                        if (m_mce != 0 && (host_wdata & 15) != m_clk) begin
                            m_clk = host_wdata & 15;
                            m_left = WIN;
                        end
                    end
                    2: m_alt = host_wdata & 1;
                    default: ;
                endcase
            end
        end
    end

    // compare every output with the model on each falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 busy vs model", busy, (m_left != 0));
            chk("R2 mce vs model", mce, m_mce);
            chk("R9 alt vs model", alt_rate_en, m_alt);
            chk("R9 live vs model", clk_fields_live, 1 - m_alt);
            chk("R3 fmt vs model", fmt_bits, m_fmt);
            chk("R7 clk vs model", {clk_div_sel, clk_base_sel}, m_clk);
            chk("R10 rdata vs model", host_rdata, m_rd);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        host_addr = 2'(a); host_wdata = 8'(d); host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        host_addr = 2'(a); host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    initial begin
        int v;
        int len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 mce", mce, 0);
        chk("R1 alt", alt_rate_en, 0);
        chk("R1 fields", {fmt_bits, clk_div_sel, clk_base_sel}, 0);
        rd(0, v); chk("R1 ctrl read", v, 'h00);
        // R7 clock write without permit
        wr(1, 'h5A);
        chk("R7 fmt", fmt_bits, 5);
        chk("R7 clk held", {clk_div_sel, clk_base_sel}, 0);
        chk("R7 no busy", busy, 0);
        // R2 set permit
        wr(0, 'hFF);
        rd(0, v); chk("R2 ctrl read", v, 'h40);
        // R8 same clock fields
        wr(1, 'h90);
        chk("R8 fmt", fmt_bits, 9);
        chk("R8 no busy", busy, 0);
        // R3 real change
        wr(1, 'h37);
        chk("R3 busy raised", busy, 1);
        chk("R3 div", clk_div_sel, 3);
        chk("R3 base", clk_base_sel, 1);
        len = 1;
        // R6 reads during busy
        rd(0, v); chk("R6 ctrl busy read", v, 'h80); len++;
        rd(1, v); chk("R6 rate busy read", v, 'h80); len++;
        // R5 writes dropped
        wr(2, 'h01); len++;
        chk("R5 alt held", alt_rate_en, 0);
        wr(0, 'h00); len++;
        chk("R5 mce held", mce, 1);
        wr(1, 'hF2); len++;
        chk("R5 rate held", {fmt_bits, clk_div_sel, clk_base_sel}, 'h37);
        smp_tick = 1'b1;
        while (busy) begin
            @(negedge clk);
            smp_tick = ~smp_tick;
            if (busy) len++;
        end
        smp_tick = 1'b0;
        chk("R4 window length", len, WIN);
        // R6 normal reads after window
        rd(1, v); chk("R6 rate after", v, 'h37);
        rd(0, v); chk("R6 ctrl after", v, 'h40);
        wr(0, 'h00);
        chk("R2 mce cleared", mce, 0);
        // R9 alternate flag
        wr(2, 'h01);
        chk("R9 alt set", alt_rate_en, 1);
        chk("R9 live off", clk_fields_live, 0);
        rd(2, v); chk("R9 alt read", v, 'h01);
        // R10 spare address, hold without strobe
        rd(3, v); chk("R10 spare read", v, 'h00);
        wr(1, 'h2C);
        chk("R7 clk kept", {clk_div_sel, clk_base_sel}, 7);
        @(negedge clk);
        chk("R10 hold", host_rdata, 'h00);
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule